// File: doc/BRIEF.md
# No-Retire Freeze Detector and Performance Counters

This block sits beside a processor core and watches its retire strobe. It counts how many cycles in a row pass with no instruction retiring. When that run reaches a programmable limit, the block takes a single snapshot of the program counter and of a word that combines the core's FSM state with its last exception vector. It also raises a sticky frozen flag. A wedge that lasts only a moment stays on record until software clears it, and later stalls cannot overwrite it.

Beside the detector, five free-running counters measure elapsed cycles, retired instructions, no-retire cycles, I/O-wait cycles and interrupt events, so software can compute CPI. Each counter is wider than the register port and is read in two halves. A single write to the control register zeroes the snapshot, the flag, the run length and every counter.

Top module: `stall_watch`

## Requirements
- R1: After synchronous active-low reset, frozen_o is 0. The threshold, the snapshot registers, the run length and all counters are 0, and the read data register is 0.
- R2: The cycle counter (low half at address 5, high half at address 6) advances by one every cycle after reset and wraps at 2^CNT_W.
- R3: The retired counter (addresses 7/8) advances by one in each cycle that retire_i is 1, and never exceeds the cycle counter.
- R4: The stall counter (addresses 9/10) counts cycles with retire_i at 0. The I/O-wait counter (11/12) counts cycles with io_wait_i at 1. The interrupt counter (13/14) counts cycles with irq_i at 1.
- R5: The threshold register (address 1) holds T. When T is nonzero and retire_i stays 0 for T consecutive cycles, frozen_o reads 1 in the cycle after the T-th such cycle.
- R6: A cycle with retire_i at 1 restarts the consecutive no-retire run from zero, so it cannot set frozen_o.
- R7: On the trip cycle, pc_i is captured into the snapshot PC register (address 3), and {fsm_i, vec_i} into the snapshot state register (address 4, fsm in the upper byte). The status register (address 2) shows the frozen flag at bit 18, and every other status bit is 0.
- R8: While frozen, the flag and both snapshot registers keep their values until a clear, whatever stalls follow.
- R9: A threshold of 0 disables freeze detection.
- R10: Writing address 0 with bit 0 set clears the flag, the snapshots, the run length, all counters and all high-half shadows at that clock edge. A clear takes priority over a trip or a count in the same cycle. The threshold is kept.
- R11: Reading a counter's low half also latches its high half into a shadow. Reading the high half returns that shadow, so the two halves come from the same cycle.
- R12: A read strobe with an address returns data on bus_rdata_o in the following cycle, and the data holds until the next read. Addresses 0 and 15 read as 0. A write to the threshold takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| retire_i | input | 1 | One instruction retired this cycle |
| pc_i | input | PC_W | Current program counter |
| fsm_i | input | FSM_W | Core FSM state |
| vec_i | input | VEC_W | Last exception/interrupt vector |
| io_wait_i | input | 1 | Core waiting on I/O this cycle |
| irq_i | input | 1 | Interrupt event strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, one cycle after the strobe |
| frozen_o | output | 1 | Sticky freeze flag |

## Verification
The hardest case to reach is a read of a counter's low half in the very cycle before that half carries into the high half. At full width this needs 2^32 cycles. The bench therefore builds the block with 20-bit counters, which makes each half 10 bits, and it polls its own model until the cycle counter's low half reads all ones. It then issues the low read in that cycle and the high read one cycle later, after the carry. The other hard timing case is a clear that lands in the exact cycle a freeze would trip. The bench builds it on purpose by holding retire_i low until one cycle short of the threshold.

// File: rtl/stall_watch_pkg.sv
// Package: shared register addresses and constants for the stall watch block.
// Assumes a 4-bit word address on the register port.
package stall_watch_pkg;
    localparam logic [3:0] A_CTRL     = 4'd0;
    localparam logic [3:0] A_THRESH   = 4'd1;
    localparam logic [3:0] A_STATUS   = 4'd2;
    localparam logic [3:0] A_SNAP_PC  = 4'd3;
    localparam logic [3:0] A_SNAP_ST  = 4'd4;
    localparam int         CNT_BASE   = 5;    // low half of counter k at CNT_BASE+2k
    localparam int         N_CNT      = 5;    // cycle, retired, stall, io-wait, irq
    localparam int         FROZEN_BIT = 18;   // frozen flag position in status word
    localparam int         CLR_BIT    = 0;    // clear bit in control word
endpackage

// File: rtl/sw_perf_counter.sv
// Module: one free-running event counter with a high-half shadow.
// Counts inc pulses, wraps at 2^CNT_W. A low-half read (snap_hi) latches the
// upper half so a later high-half read matches the low value already returned.
// Assumes CNT_W is even; clr has priority over everything else.
module sw_perf_counter #(
    parameter int CNT_W = 64,
    localparam int HALF = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             snap_hi,
    output logic [CNT_W-1:0] cnt_o,
    output logic [HALF-1:0]  hi_shadow_o
);
    // Count events; cleared on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_o <= '0;
        else if (clr) cnt_o <= '0;
        else if (inc) cnt_o <= cnt_o + 1'b1;
    end

    // Hold the upper half captured at the last low-half read.
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_shadow_o <= '0;
        else if (clr)     hi_shadow_o <= '0;
        else if (snap_hi) hi_shadow_o <= cnt_o[CNT_W-1:HALF];
    end
endmodule

// File: rtl/sw_freeze_detect.sv
// Module: consecutive no-retire run counter with a one-shot freeze snapshot.
// The run length saturates, and any retire zeroes it. When the threshold is
// nonzero and a no-retire cycle brings the run to the threshold or beyond,
// the PC and state word of that cycle are latched and the flag is set. The
// snapshot stays put until clr. Assumes clr is a one-cycle pulse.
module sw_freeze_detect #(
    parameter int TH_W = 32,
    parameter int PC_W = 32,
    parameter int ST_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            retire,
    input  logic [TH_W-1:0] thresh,
    input  logic [PC_W-1:0] pc,
    input  logic [ST_W-1:0] st_word,
    output logic            frozen_o,
    output logic [PC_W-1:0] snap_pc_o,
    output logic [ST_W-1:0] snap_st_o
);
    localparam logic [TH_W-1:0] RUN_MAX = '1;

    logic [TH_W-1:0] run_q;
    logic [TH_W-1:0] run_nxt;
    logic            trip;

    // Next run length: zero on retire, otherwise saturating increment.
    always_comb begin
        if (retire)              run_nxt = '0;
        else if (run_q == RUN_MAX) run_nxt = run_q;
        else                     run_nxt = run_q + 1'b1;
    end

    // Trip when armed, stalled and the run has reached the threshold.
    assign trip = !retire && (thresh != '0) && (run_nxt >= thresh) && !frozen_o;

    // Track the consecutive no-retire run.
    always_ff @(posedge clk) begin
        if (!rst_n)   run_q <= '0;
        else if (clr) run_q <= '0;
        else          run_q <= run_nxt;
    end

    // One-shot capture of flag and snapshot words.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            frozen_o  <= 1'b0;
            snap_pc_o <= '0;
            snap_st_o <= '0;
        end else if (trip) begin
            frozen_o  <= 1'b1;
            snap_pc_o <= pc;
            snap_st_o <= st_word;
        end
    end
endmodule

// File: rtl/stall_watch.sv
// Module: stall watch top. Holds the freeze detector, the five performance
// counters, the threshold register and the word-addressed register port.
// Reads are registered (data one cycle after bus_rd_i). Assumes PC_W, TH_W
// and FSM_W+VEC_W fit in DATA_W, DATA_W > 18, and CNT_W/2 <= DATA_W.
module stall_watch
    import stall_watch_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int FSM_W  = 8,
    parameter int VEC_W  = 8,
    parameter int CNT_W  = 64,
    parameter int DATA_W = 32,
    parameter int TH_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [FSM_W-1:0]  fsm_i,
    input  logic [VEC_W-1:0]  vec_i,
    input  logic              io_wait_i,
    input  logic              irq_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [3:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              frozen_o
);
    localparam int ST_W = FSM_W + VEC_W;
    localparam int HALF = CNT_W / 2;

    logic                          clr_pulse;
    logic [TH_W-1:0]               thr_q;
    logic [PC_W-1:0]               snap_pc;
    logic [ST_W-1:0]               snap_st;
    logic [N_CNT-1:0]              cnt_inc;
    logic [N_CNT-1:0]              lo_read;
    logic [N_CNT-1:0][CNT_W-1:0]   cnt_val;
    logic [N_CNT-1:0][HALF-1:0]    cnt_shadow;
    logic [DATA_W-1:0]             rd_mux;

    // Clear strobe decoded from a control write.
    assign clr_pulse = bus_wr_i && (bus_addr_i == A_CTRL) && bus_wdata_i[CLR_BIT];

    // Threshold register; survives the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  thr_q <= '0;
        else if (bus_wr_i && bus_addr_i == A_THRESH) thr_q <= bus_wdata_i[TH_W-1:0];
    end

    sw_freeze_detect #(
        .TH_W(TH_W), .PC_W(PC_W), .ST_W(ST_W)
    ) u_freeze (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_pulse),
        .retire   (retire_i),
        .thresh   (thr_q),
        .pc       (pc_i),
        .st_word  ({fsm_i, vec_i}),
        .frozen_o (frozen_o),
        .snap_pc_o(snap_pc),
        .snap_st_o(snap_st)
    );

    // Event sources in counter order: cycle, retired, stall, io-wait, irq.
    assign cnt_inc = {irq_i, io_wait_i, !retire_i, retire_i, 1'b1};

    for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
        assign lo_read[k] = bus_rd_i && (bus_addr_i == 4'(CNT_BASE + 2 * k));
        sw_perf_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (clr_pulse),
            .inc        (cnt_inc[k]),
            .snap_hi    (lo_read[k]),
            .cnt_o      (cnt_val[k]),
            .hi_shadow_o(cnt_shadow[k])
        );
    end

    // Select the word addressed by the read port.
    always_comb begin
        rd_mux = '0;
        case (bus_addr_i)
            A_THRESH:  rd_mux[TH_W-1:0] = thr_q;
            A_STATUS:  rd_mux[FROZEN_BIT] = frozen_o;
            A_SNAP_PC: rd_mux[PC_W-1:0] = snap_pc;
            A_SNAP_ST: rd_mux[ST_W-1:0] = snap_st;
            default:   ;
        endcase
        for (int k = 0; k < N_CNT; k++) begin
            if (bus_addr_i == 4'(CNT_BASE + 2 * k))
                rd_mux = DATA_W'(cnt_val[k][HALF-1:0]);
            if (bus_addr_i == 4'(CNT_BASE + 2 * k + 1))
                rd_mux = DATA_W'(cnt_shadow[k]);
        end
    end

    // Register read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        bus_rdata_o <= '0;
        else if (bus_rd_i) bus_rdata_o <= rd_mux;
    end
endmodule

// File: rtl/stall_watch_checker.sv
// Module: assertion checker bound into stall_watch. Watches the flag, the
// snapshots, the threshold and the cycle/retired counters over time.
module stall_watch_checker #(
    parameter int PC_W  = 32,
    parameter int ST_W  = 16,
    parameter int CNT_W = 64,
    parameter int TH_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             retire_i,
    input logic             clr,
    input logic [TH_W-1:0]  thr,
    input logic             frozen,
    input logic [PC_W-1:0]  snap_pc,
    input logic [ST_W-1:0]  snap_st,
    input logic [CNT_W-1:0] cyc,
    input logic [CNT_W-1:0] ret
);
    assert_cycle_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cyc == CNT_W'($past(cyc) + 1'b1));

    assert_ret_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ret <= cyc);

    assert_retire_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        retire_i && !frozen |=> !frozen);

    assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frozen && !clr |=> frozen);

    assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frozen && !clr |=> $stable(snap_pc) && $stable(snap_st));

    assert_zero_thresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
        thr == '0 && !frozen |=> !frozen);

    assert_clear_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !frozen && cyc == '0 && ret == '0 && snap_pc == '0 && snap_st == '0);
endmodule

bind stall_watch stall_watch_checker #(
    .PC_W(PC_W), .ST_W(FSM_W + VEC_W), .CNT_W(CNT_W), .TH_W(TH_W)
) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .retire_i(retire_i),
    .clr     (clr_pulse),
    .thr     (thr_q),
    .frozen  (frozen_o),
    .snap_pc (snap_pc),
    .snap_st (snap_st),
    .cyc     (cnt_val[0]),
    .ret     (cnt_val[1])
);

// File: tb/stall_watch_bench.sv
`timescale 1ns/1ps
module stall_watch_bench;
    localparam int CW = 20;
    localparam int HW = CW / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire = 1'b1;
    logic [31:0] pc = '0;
    logic [7:0]  fsm = '0;
    logic [7:0]  vec = '0;
    logic        io_wait = 1'b0;
    logic        irq = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        frozen;

    always #2.5 clk = ~clk;

    stall_watch #(.CNT_W(CW)) u_stall_watch (
        .clk(clk), .rst_n(rst_n), .retire_i(retire), .pc_i(pc), .fsm_i(fsm),
        .vec_i(vec), .io_wait_i(io_wait), .irq_i(irq), .bus_wr_i(bus_wr),
        .bus_rd_i(bus_rd), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .frozen_o(frozen)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state, built from the requirements.
    logic [CW-1:0] m_cnt [5];
    logic [HW-1:0] m_sh  [5];
    logic          m_frozen;
    logic [31:0]   m_spc;
    logic [15:0]   m_sst;
    logic [31:0]   m_thr;
    logic [31:0]   m_run;
    logic [31:0]   exp_rd;
    logic [31:0]   nrun;
    logic          m_clr;

    function automatic logic [31:0] m_read(logic [3:0] a);
        int k;
        if (a == 4'd1) return m_thr;
        if (a == 4'd2) return {13'b0, m_frozen, 18'b0};
        if (a == 4'd3) return m_spc;
        if (a == 4'd4) return {16'b0, m_sst};
        if (a >= 4'd5 && a <= 4'd14) begin
            k = (int'(a) - 5) / 2;
            if (((int'(a) - 5) % 2) == 0) return 32'(m_cnt[k][HW-1:0]);
            return 32'(m_sh[k]);
        end
        return '0;
    endfunction

    function automatic string req_of(logic [3:0] a);
        if (a == 4'd5 || a == 4'd6)   return "R2";
        if (a == 4'd7 || a == 4'd8)   return "R3";
        if (a >= 4'd9 && a <= 4'd14)  return "R4";
        if (a >= 4'd2 && a <= 4'd4)   return "R7";
        return "R12";
    endfunction

    // Model update at each rising edge, using the inputs held since the falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 5; k++) begin m_cnt[k] = '0; m_sh[k] = '0; end
            m_frozen = 1'b0; m_spc = '0; m_sst = '0; m_thr = '0; m_run = '0; exp_rd = '0;
        end else begin
            m_clr = bus_wr && bus_addr == 4'd0 && bus_wdata[0];
            if (bus_rd) exp_rd = m_read(bus_addr);
            if (m_clr) begin
                for (int k = 0; k < 5; k++) begin m_cnt[k] = '0; m_sh[k] = '0; end
                m_frozen = 1'b0; m_spc = '0; m_sst = '0; m_run = '0;
            end else begin
                for (int k = 0; k < 5; k++)
                    if (bus_rd && bus_addr == 4'(5 + 2 * k)) m_sh[k] = m_cnt[k][CW-1:HW];
                m_cnt[0] = m_cnt[0] + 1'b1;
                if (retire) m_cnt[1] = m_cnt[1] + 1'b1;
                else        m_cnt[2] = m_cnt[2] + 1'b1;
                if (io_wait) m_cnt[3] = m_cnt[3] + 1'b1;
                if (irq)     m_cnt[4] = m_cnt[4] + 1'b1;
                nrun = retire ? 32'd0 : ((m_run == 32'hFFFF_FFFF) ? m_run : m_run + 1);
                if (!retire && m_thr != 0 && !m_frozen && nrun >= m_thr) begin
                    m_frozen = 1'b1; m_spc = pc; m_sst = {fsm, vec};
                end
                m_run = nrun;
            end
            if (bus_wr && bus_addr == 4'd1) m_thr = bus_wdata;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] v);
        bus_rd = 1'b1; bus_addr = a;
        tick();
        bus_rd = 1'b0;
        v = bus_rdata;
        chk(req_of(a), bus_rdata, exp_rd);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic stall(int n);
        retire = 1'b0;
        for (int i = 0; i < n; i++) begin pc = pc + 4; tick(); end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        logic [CW-1:0] held;
        void'($urandom(32'd4242));
        tick(); tick(); tick();
        // R1: reset state seen at the ports
        chk("R1", {31'b0, frozen}, 32'd0);
        chk("R1", bus_rdata, 32'd0);
        rst_n = 1'b1;
        for (int a = 0; a < 16; a++) rd(4'(a), v);
        rd(4'd2, v); chk("R1", v, 32'd0);

        // R5/R7: threshold 5, exactly five stalled cycles trip
        retire = 1'b1;
        wr(4'd1, 32'd5);
        rd(4'd1, v); chk("R12", v, 32'd5);
        pc = 32'h0000_0FFC; fsm = 8'hA5; vec = 8'h3C;
        stall(4);
        chk("R5", {31'b0, frozen}, 32'd0);
        stall(1);
        chk("R5", {31'b0, frozen}, 32'd1);
        rd(4'd3, v); chk("R7", v, 32'h0000_1010);
        rd(4'd4, v); chk("R7", v, 32'h0000_A53C);
        rd(4'd2, v); chk("R7", v, 32'h0004_0000);

        // R8: later stalls leave the snapshot alone
        retire = 1'b1; tick();
        fsm = 8'h11; vec = 8'h22;
        stall(12);
        rd(4'd3, v); chk("R8", v, 32'h0000_1010);
        rd(4'd4, v); chk("R8", v, 32'h0000_A53C);
        chk("R8", {31'b0, frozen}, 32'd1);

        // R10: clear zeroes flag, snapshot and counters; threshold kept
        wr(4'd0, 32'd1);
        chk("R10", {31'b0, frozen}, 32'd0);
        rd(4'd5, v); chk("R10", v, 32'd0);
        rd(4'd3, v); chk("R10", v, 32'd0);
        rd(4'd1, v); chk("R10", v, 32'd5);

        // R6: a retire every fourth cycle keeps the run short of 4
        retire = 1'b1; tick();
        wr(4'd1, 32'd4);
        for (int i = 0; i < 20; i++) begin stall(3); retire = 1'b1; tick(); end
        chk("R6", {31'b0, frozen}, 32'd0);

        // R9: threshold 0 never trips
        wr(4'd1, 32'd0);
        stall(60);
        chk("R9", {31'b0, frozen}, 32'd0);
        rd(4'd2, v); chk("R9", v, 32'd0);

        // R10: clear in the same cycle as the trip wins, run restarts
        retire = 1'b1;
        wr(4'd1, 32'd3);
        stall(2);
        wr(4'd0, 32'd1);
        chk("R10", {31'b0, frozen}, 32'd0);
        stall(2);
        chk("R10", {31'b0, frozen}, 32'd0);
        stall(1);
        chk("R10", {31'b0, frozen}, 32'd1);

        // R11: read low half just before its carry, high half after
        retire = 1'b1; wr(4'd0, 32'd1);
        for (int rep = 0; rep < 2; rep++) begin
            while (m_cnt[0][HW-1:0] != '1) tick();
            held = m_cnt[0];
            rd(4'd5, v); chk("R11", v, 32'(held[HW-1:0]));
            rd(4'd6, v); chk("R11", v, 32'(held[CW-1:HW]));
        end

        // Random traffic checked against the model
        for (int seg = 0; seg < 30; seg++) begin
            int dens;
            dens = int'($urandom_range(0, 9));
            if ($urandom_range(0, 3) == 0) wr(4'd1, $urandom_range(0, 8));
            for (int c = 0; c < 120; c++) begin
                retire  = ($urandom_range(0, 9) < dens);
                io_wait = ($urandom_range(0, 3) == 0);
                irq     = ($urandom_range(0, 15) == 0);
                pc      = $urandom;
                fsm     = 8'($urandom);
                vec     = 8'($urandom);
                if ($urandom_range(0, 199) == 0) wr(4'd0, 32'd1);
                else if ($urandom_range(0, 2) == 0) rd(4'($urandom_range(0, 15)), v);
                else tick();
                chk("R5", {31'b0, frozen}, {31'b0, m_frozen});
            end
        end
        io_wait = 1'b0; irq = 1'b0;
        finish_run();
    end
endmodule